// File: doc/BRIEF.md
# Tracking Error Fault Monitor

This block watches the signed angle error of one tracking position loop. It also watches a signal-present indication from the analog front end. From these it drives a single active-low fault flag. Each strobed error sample is turned into a magnitude. The magnitude passes through a first-order low-pass filter, and the filtered value is compared against a threshold.

The filter time constant is set by a shift parameter. With the default shift of 4 and a 32 kHz strobe rate, the time constant is about 500 µs. Because of the filter, brief spikes do not raise the flag. A large step, an overvelocity condition where the loop cannot keep up, or any other error that persists pulls the flag low. The flag goes high again by itself once the loop settles. A separate loss-of-signal input forces the flag low at once, whatever the error is.

Top module: `trk_err_bit`

## Requirements
- R1: While rst_ni is low, and after its release, the filter state is zero and bit_n_o reads 1.
- R2: bit_n_o is 0 when the filtered magnitude is strictly greater than THRESH (default 100). A filtered magnitude equal to THRESH leaves the flag at 1, so a constant input of 100 never faults and a constant input of 101 eventually does.
- R3: The filter keeps an accumulator a, with filtered value y = floor(a / 2^SHIFT_K). On each accepted sample, a becomes a + |e| − y. After an update, y lies between its old value and |e| (inclusive).
- R4: err_i is accepted only in cycles where err_vld_i is 1. Changes on err_i without the strobe leave the filter and the flag unchanged.
- R5: The magnitude is sign-symmetric: e and −e give the same result. The most negative input (−2^(ERR_W−1)) gives 2^(ERR_W−1) without wrapping.
- R6: When sig_lost_i is 1 at a rising edge, bit_n_o is 0 after that edge, regardless of the filtered error.
- R7: The flag clears by itself. Once sig_lost_i is 0 and zero-error samples have brought y back to THRESH or below, bit_n_o returns to 1 with no other action.
- R8: A sample strobed at rising edge E0 affects bit_n_o from edge E0+2 onward. After edge E0+1 the flag still shows the earlier state.
- R9: A sustained large error, such as an overvelocity condition, drives bit_n_o to 0 through the filtered threshold path and holds it there while the error persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_i | input | ERR_W | Signed tracking error sample, in LSBs |
| err_vld_i | input | 1 | Sample strobe; err_i is taken when 1 |
| sig_lost_i | input | 1 | Loss of all input signals when 1 |
| bit_n_o | output | 1 | Fault flag, 0 = fault |

## Verification
The assertions assume that err_vld_i and sig_lost_i are clean synchronous levels, and that err_i is held stable in any cycle where it is strobed. Under those conditions the accumulator can only change on a strobe and can only move toward the new magnitude. The stimulus changes every input on the falling clock edge. It strobes each sample for exactly one cycle, and it waits at least two edges before the next strobe, so the latency window of R8 is observed cleanly. The bench computes its expected flag from the accumulator formula of R3 and the threshold of R2. It covers constant errors on both sides of the threshold, both signs, the most negative code, and periods with no strobe.

// File: rtl/trk_err_bit_pkg.sv
package trk_err_bit_pkg;
  localparam int unsigned DEF_ERR_W   = 16;
  localparam int unsigned DEF_SHIFT_K = 4;   // 2^4 samples at 32 kHz ~ 500 us
  localparam int unsigned DEF_THRESH  = 100;
endpackage

// File: rtl/trk_err_mag.sv
module trk_err_mag #(
  parameter int unsigned ERR_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    vld_i,
  output logic        [ERR_W-1:0] mag_o,
  output logic                    vld_o
);
  logic [ERR_W-1:0] mag_q;
  logic             vld_q;

  // negating the most negative code yields 2^(ERR_W-1) when read unsigned
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) mag_q <= err_i[ERR_W-1] ? $unsigned(-err_i) : $unsigned(err_i);
    end
  end

  assign mag_o = mag_q;
  assign vld_o = vld_q;

  // R5: magnitude never exceeds 2^(ERR_W-1)
  a_r5_mag_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mag_o <= {1'b1, {(ERR_W-1){1'b0}}});
  // R5: sign symmetry, a strobed non-negative sample passes unchanged
  a_r5_pos_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !err_i[ERR_W-1]) |=> (mag_o == $past($unsigned(err_i))));
endmodule

// File: rtl/trk_err_iir.sv
module trk_err_iir #(
  parameter int unsigned MAG_W   = 16,
  parameter int unsigned SHIFT_K = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             vld_i,
  output logic [MAG_W-1:0] filt_o
);
  localparam int unsigned ACC_W = MAG_W + SHIFT_K;
  localparam int unsigned SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  // acc holds y*2^K; acc + |e| - y stays within [0, 2^K * max|e|]
  always_comb begin
    sum = {1'b0, acc_q} + SUM_W'(mag_i) - SUM_W'(acc_q >> SHIFT_K);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (vld_i) acc_q <= sum[ACC_W-1:0];
  end

  assign filt_o = acc_q[ACC_W-1:SHIFT_K];

  initial a_r3_shift_ok: assert (SHIFT_K >= 1);

  // R4: no strobe, no change
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(acc_q));
  // R3: update moves toward the sample and does not pass it
  a_r3_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && mag_i >= filt_o) |=> (filt_o >= $past(filt_o) && filt_o <= $past(mag_i)));
  a_r3_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && mag_i <= filt_o) |=> (filt_o <= $past(filt_o) && filt_o >= $past(mag_i)));
  // R3: no overflow of the scaled state
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sum[ACC_W]);
endmodule

// File: rtl/trk_err_flag.sv
module trk_err_flag #(
  parameter int unsigned MAG_W  = 16,
  parameter int unsigned THRESH = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] filt_i,
  input  logic             lost_i,
  output logic             fault_n_o
);
  localparam logic [MAG_W-1:0] THR_V = MAG_W'(THRESH);

  logic fault_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_n_q <= 1'b1;
    else         fault_n_q <= !(lost_i || (filt_i > THR_V));
  end

  assign fault_n_o = fault_n_q;

  a_r6_lost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_i |=> !fault_n_o);
  a_r2_over: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_i > THR_V) |=> !fault_n_o);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lost_i && filt_i <= THR_V) |=> fault_n_o);
endmodule

// File: rtl/trk_err_bit.sv
module trk_err_bit
  import trk_err_bit_pkg::*;
#(
  parameter int unsigned ERR_W   = DEF_ERR_W,
  parameter int unsigned SHIFT_K = DEF_SHIFT_K,
  parameter int unsigned THRESH  = DEF_THRESH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic                    err_vld_i,
  input  logic                    sig_lost_i,
  output logic                    bit_n_o
);
  logic [ERR_W-1:0] mag;
  logic             mag_vld;
  logic [ERR_W-1:0] filt;

  trk_err_mag #(.ERR_W(ERR_W)) u_mag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .err_i (err_i),
    .vld_i (err_vld_i),
    .mag_o (mag),
    .vld_o (mag_vld)
  );

  trk_err_iir #(.MAG_W(ERR_W), .SHIFT_K(SHIFT_K)) u_iir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mag_i (mag),
    .vld_i (mag_vld),
    .filt_o(filt)
  );

  trk_err_flag #(.MAG_W(ERR_W), .THRESH(THRESH)) u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .filt_i   (filt),
    .lost_i   (sig_lost_i),
    .fault_n_o(bit_n_o)
  );

  // R8: a strobe cannot change the flag at the very next edge unless loss is flagged
  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_vld_i && !mag_vld && !sig_lost_i && !$isunknown(filt)) |=> (bit_n_o == $past(filt <= ERR_W'(THRESH))));
endmodule

// File: tb/trk_err_bit_tb.sv
module trk_err_bit_tb_top;
  localparam int ERR_W = 16;
  localparam int K     = 4;
  localparam int THR   = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [ERR_W-1:0] err = '0;
  logic vld = 1'b0;
  logic lost = 1'b0;
  logic bit_n;

  int checks = 0;
  int fails = 0;
  longint acc = 0;
  logic exp_flag = 1'b1;

  always #2 clk = ~clk;

  trk_err_bit #(.ERR_W(ERR_W), .SHIFT_K(K), .THRESH(THR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .err_i(err), .err_vld_i(vld),
    .sig_lost_i(lost), .bit_n_o(bit_n));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s bit_n_o act=%0b exp=%0b acc=%0d", req, act, exp, acc);
    end
  endtask

  function automatic logic model_flag();
    return !(lost || ((acc >> K) > THR));
  endfunction

  // strobe one sample; check old flag after E0+1 and new flag after E0+2
  task automatic send(input int e, input string req);
    longint m;
    logic prev;
    prev = exp_flag;
    m = (e < 0) ? -e : e;
    @(negedge clk); err = ERR_W'(e); vld = 1'b1;
    @(posedge clk);
    @(negedge clk); vld = 1'b0; err = 16'h5a5a;
    acc = acc + m - (acc >> K);
    exp_flag = model_flag();
    @(posedge clk); #1;
    check({req, "/R8 hold"}, bit_n, prev);
    @(posedge clk); #1;
    check(req, bit_n, exp_flag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 in reset", bit_n, 1'b1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R1 after reset", bit_n, 1'b1);
    acc = 0; exp_flag = 1'b1;
  endtask

  task automatic t_threshold();
    for (int i = 0; i < 150; i++) send(100, "R2 at thresh");
    check("R2 equal no fault", bit_n, 1'b1);
    for (int i = 0; i < 150; i++) send(101, "R2 above");
    check("R2 above faults", bit_n, 1'b0);
  endtask

  task automatic t_settle();
    for (int i = 0; i < 200; i++) send(0, "R7 settle");
    check("R7 self clear", bit_n, 1'b1);
  endtask

  task automatic t_step();
    send(4000, "R3 step");
    send(4000, "R9 sustained");
    for (int i = 0; i < 20; i++) send(3000, "R9 sustained");
    check("R9 held low", bit_n, 1'b0);
  endtask

  task automatic t_negative();
    for (int i = 0; i < 150; i++) send(-101, "R5 negative");
    check("R5 negative faults", bit_n, 1'b0);
    t_settle();
    for (int i = 0; i < 150; i++) send(-100, "R5 neg at thresh");
    check("R5 neg equal ok", bit_n, 1'b1);
    t_settle();
    send(-32768, "R5 min code");
    send(-32768, "R5 min code");
    check("R5 min code faults", bit_n, 1'b0);
    t_settle();
  endtask

  task automatic t_no_strobe();
    @(negedge clk); vld = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); err = ERR_W'(16'sd20000 - 16'(i));
    end
    repeat (3) @(posedge clk); #1;
    check("R4 ignored", bit_n, 1'b1);
    send(0, "R4 state intact");
  endtask

  task automatic t_loss();
    @(negedge clk); lost = 1'b1;
    @(posedge clk); #1;
    check("R6 lost next edge", bit_n, 1'b0);
    exp_flag = model_flag();
    send(0, "R6 lost held");
    @(negedge clk); lost = 1'b0;
    @(posedge clk); #1;
    exp_flag = model_flag();
    check("R7 clear after loss", bit_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_threshold();
    t_settle();
    t_step();
    t_settle();
    t_negative();
    t_no_strobe();
    t_loss();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule